// File: doc/BRIEF.md
# I2C Engine Host Register File and Byte FIFO

This block is the host-facing side of an I2C engine. A host issues 32-bit word accesses at byte offsets. The block decodes those accesses into a mode register, a watermark register and a command register, and into two status words that it assembles. A single byte FIFO sits behind the data offset. The host pushes bytes into the FIFO for the bus sequencer to transmit, and it pops bytes that the sequencer has received. The bus sequencer connects on the other side through its own push and pop strobes, its error pulses and its live status lines.

Some offsets behave differently for a read and for a write. A read of the status offset returns the status word, and a write to it resets the whole engine. A read of the extended-status offset returns that word, and a write to it clears the sticky error flags. A write to the port-busy offset clears the port-busy indication, but only when bit 31 of the data is set.

Host accesses pass through a small state machine with three states. `ST_IDLE` accepts a request. `ST_RESP` presents read data. `ST_RST` holds the engine in reset. It has these transitions:
- **read-accept**: `ST_IDLE` to `ST_RESP`.
- **resp-done**: `ST_RESP` back to `ST_IDLE` after one cycle.
- **reset-write**: `ST_IDLE` to `ST_RST`.
- **reset-done**: `ST_RST` to `ST_IDLE` once the hold counter expires.

Every other write leaves the machine in `ST_IDLE`.

Top module: `i2c_host_regfile`

## Requirements
- R1: After reset the mode, watermark and command registers read 0 and the FIFO is empty. Status reads `0x0003_0000` plus the SCL and SDA levels at bits 11 and 10. Extended status reads `0x0800_0302`: FIFO size 8 in bits 31:24, both watermark flags set, and version 2 in bits 4:0.
- R2: The mode register (offset `0x08`) keeps only the clock divider (bits 31:16), the port select (bits 15:10), enhanced (bit 3), diagnostic (bit 2), pacing (bit 1) and wrap (bit 0). The other bits read as 0. Each field drives its own output.
- R3: The watermark register (offset `0x0C`) keeps only the high threshold (bits 15:12) and the low threshold (bits 7:4). The high flag (extended status bit 9 and `wm_high`) is 1 when count ≥ high threshold. The low flag (bit 8 and `wm_low`) is 1 when count ≤ low threshold.
- R4: FIFO order and count.
  - Host writes to offset `0x00` push the low data byte, and the engine pops these bytes in the order they were written.
  - Engine pushes are returned to host reads of `0x00` in the same order, in bits 7:0, with the upper bits zero.
  - Status bits 7:0 show the live byte count.
- R5: A host FIFO write while the FIFO is full, or a host FIFO read while it is empty, sets the sticky overrun bit (status bit 29). It leaves the count and the contents unchanged. An empty read returns 0.
- R6: The engine error pulses set sticky status bits:
  - `eng_err[0]` sets invalid-command, bit 31.
  - `eng_err[1]` sets parity, bit 30.
  - `eng_err[2]` sets access, bit 28.
  - `eng_err[3]` sets lost arbitration, bit 27.
  - `eng_err[4]` sets NACK, bit 26.
  - `eng_err[5]` sets stop error, bit 23.

  Bit 15 is the OR of all seven error bits.
- R7: A write to offset `0x20` clears every sticky error bit.
- R8: A write to offset `0x1C` holds `eng_rst` high and `host_ready` low for 4 cycles. During the hold, the mode, watermark and command registers, the FIFO, the errors and port-busy are all cleared.
- R9: `eng_port_busy_set` sets a sticky port-busy bit (status bit 9). A write to offset `0x28` clears it only when data bit 31 is 1, and has no effect otherwise.
- R10: A write to offset `0x04` stores the word, which reads back unchanged. It raises `cmd_valid` for exactly one cycle with that word on `cmd_word`.
- R11: Status bits 25, 24, 11, 10 and 8 follow the live inputs data-request, command-complete, SCL, SDA and self-busy.
- R12: After a read is accepted, `host_rvalid` is high and `host_ready` is low for exactly the next cycle, with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Block can accept a request |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_word | output | 32 | Stored command word |
| mode_clk_div | output | 16 | Clock divider field |
| mode_port | output | 6 | Port select field |
| mode_enhanced | output | 1 | Enhanced mode bit |
| mode_diag | output | 1 | Diagnostic mode bit |
| mode_pace | output | 1 | Pacing-allow bit |
| mode_wrap | output | 1 | Wrap bit |
| eng_rst | output | 1 | Engine reset, held during ST_RST |
| eng_push | input | 1 | Engine pushes a received byte |
| eng_push_data | input | 8 | Byte pushed by engine |
| eng_pop | input | 1 | Engine pops a byte to transmit |
| eng_pop_data | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| eng_err | input | 6 | Engine error pulses |
| eng_dat_req | input | 1 | Live data-request |
| eng_cmd_comp | input | 1 | Live command-complete |
| eng_self_busy | input | 1 | Live self-busy |
| eng_port_busy_set | input | 1 | Sets sticky port-busy |
| scl_in | input | 1 | SCL level |
| sda_in | input | 1 | SDA level |
| wm_high | output | 1 | High-watermark flag |
| wm_low | output | 1 | Low-watermark flag |

## Verification
The assertions check four things on every cycle:
- The FIFO count never exceeds its depth.
- A host push into a full FIFO leaves the count unchanged.
- An accepted read is answered in the next cycle.
- Sticky errors stay set until a clear, and a port-busy clear takes effect.

Only the directed scenarios can show the remaining behaviour: the field positions in both status words, byte ordering through the FIFO in each direction, the watermark comparisons at their thresholds, the length of the reset hold and what it clears, and the bit-31 condition on the port-busy clear.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
    localparam int HOST_AW = 6;
    localparam int WORD_W  = 32;

    localparam logic [HOST_AW-1:0] OFS_FIFO  = 6'h00;
    localparam logic [HOST_AW-1:0] OFS_CMD   = 6'h04;
    localparam logic [HOST_AW-1:0] OFS_MODE  = 6'h08;
    localparam logic [HOST_AW-1:0] OFS_WMARK = 6'h0C;
    localparam logic [HOST_AW-1:0] OFS_STAT  = 6'h1C;
    localparam logic [HOST_AW-1:0] OFS_ESTAT = 6'h20;
    localparam logic [HOST_AW-1:0] OFS_PBUSY = 6'h28;

    localparam logic [WORD_W-1:0] MODE_KEEP  = 32'hFFFF_FC0F;
    localparam logic [WORD_W-1:0] WMARK_KEEP = 32'h0000_F0F0;
    localparam int PBUSY_CLR_BIT = 31;

    localparam int NUM_ENG_ERR = 6;
    localparam int EI_INV  = 0;
    localparam int EI_PAR  = 1;
    localparam int EI_ACC  = 2;
    localparam int EI_ARB  = 3;
    localparam int EI_NACK = 4;
    localparam int EI_STOP = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_RST  = 2'd2
    } acc_state_t;

    typedef struct packed {
        logic inv_cmd;
        logic parity;
        logic overrun;
        logic access;
        logic lost_arb;
        logic nack;
        logic stop_err;
    } err_flags_t;

    typedef struct packed {
        logic fifo;
        logic cmd;
        logic mode;
        logic wmark;
        logic err_clear;
        logic pbusy;
    } wr_strobe_t;
endpackage

// File: rtl/i2cfe_ctrl.sv
module i2cfe_ctrl
    import i2cfe_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  rd_word,
    output logic               host_ready,
    output logic               host_rvalid,
    output logic [WORD_W-1:0]  host_rdata,
    output wr_strobe_t         wr_stb,
    output logic               rd_fifo,
    output logic               soft_clr
);
    localparam int RST_CW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD);

    acc_state_t        state_q;
    acc_state_t        state_d;
    logic [RST_CW-1:0] rst_cnt_q;
    logic              accept;
    logic              acc_wr;
    logic              acc_rd;

    assign accept = host_req && (state_q == ST_IDLE);
    assign acc_wr = accept && host_we;
    assign acc_rd = accept && !host_we;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_wr && (host_addr == OFS_STAT)) state_d = ST_RST;
                else if (acc_rd)                       state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            ST_RST:  if (rst_cnt_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // reset hold counter: preloaded outside ST_RST
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rst_cnt_q <= RST_CW'(RST_HOLD - 1);
        else if (state_q != ST_RST)  rst_cnt_q <= RST_CW'(RST_HOLD - 1);
        else if (rst_cnt_q != '0)    rst_cnt_q <= rst_cnt_q - 1'b1;
    end

    // read data capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      host_rdata <= '0;
        else if (acc_rd) host_rdata <= rd_word;
    end

    // outputs
    always_comb begin
        host_ready       = (state_q == ST_IDLE);
        host_rvalid      = (state_q == ST_RESP);
        soft_clr         = (state_q == ST_RST);
        wr_stb.fifo      = acc_wr && (host_addr == OFS_FIFO);
        wr_stb.cmd       = acc_wr && (host_addr == OFS_CMD);
        wr_stb.mode      = acc_wr && (host_addr == OFS_MODE);
        wr_stb.wmark     = acc_wr && (host_addr == OFS_WMARK);
        wr_stb.err_clear = acc_wr && (host_addr == OFS_ESTAT);
        wr_stb.pbusy     = acc_wr && (host_addr == OFS_PBUSY);
        rd_fifo          = acc_rd && (host_addr == OFS_FIFO);
    end

    p_read_response_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_we) |=> (host_rvalid && !host_ready))
        else $error("R12: accepted read not answered next cycle");
endmodule

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_host,
    input  logic [7:0]       din_host,
    input  logic             push_eng,
    input  logic [7:0]       din_eng,
    input  logic             pop_host,
    input  logic             pop_eng,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             host_ovr
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;
    logic [7:0]       din;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign push_ok  = (push_host || push_eng) && !full;
    assign pop_ok   = (pop_host || pop_eng) && !empty;
    assign din      = push_host ? din_host : din_eng;
    assign head     = mem[rd_ptr];
    assign host_ovr = (push_host && full) || (pop_host && empty);

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH))
        else $error("R4: FIFO count above depth");

    p_single_pusher_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_host && push_eng) && !(pop_host && pop_eng))
        else $error("R4: host and engine hit the same FIFO side at once");

    p_full_write_kept_r5: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (full && push_host && !pop_eng) |=> (count == $past(count)))
        else $error("R5: write into full FIFO changed the count");
endmodule

// File: rtl/i2cfe_stat.sv
module i2cfe_stat
    import i2cfe_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_clr,
    input  logic                   err_clr,
    input  logic [NUM_ENG_ERR-1:0] eng_err,
    input  logic                   ovr_set,
    input  logic                   pbusy_set,
    input  logic                   pbusy_clr,
    output err_flags_t             errs,
    output logic                   port_busy
);
    err_flags_t set_v;

    always_comb begin
        set_v.inv_cmd  = eng_err[EI_INV];
        set_v.parity   = eng_err[EI_PAR];
        set_v.overrun  = ovr_set;
        set_v.access   = eng_err[EI_ACC];
        set_v.lost_arb = eng_err[EI_ARB];
        set_v.nack     = eng_err[EI_NACK];
        set_v.stop_err = eng_err[EI_STOP];
    end

    // new events win over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        errs <= '0;
        else if (soft_clr) errs <= '0;
        else if (err_clr)  errs <= set_v;
        else               errs <= errs | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         port_busy <= 1'b0;
        else if (soft_clr)  port_busy <= 1'b0;
        else if (pbusy_set) port_busy <= 1'b1;
        else if (pbusy_clr) port_busy <= 1'b0;
    end

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (errs.nack && !err_clr && !soft_clr) |=> errs.nack)
        else $error("R6: sticky error dropped without a clear");

    p_pbusy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pbusy_clr && !pbusy_set) |=> !port_busy)
        else $error("R9: port busy not cleared");
endmodule

// File: rtl/i2c_host_regfile.sv
module i2c_host_regfile
    import i2cfe_pkg::*;
#(
    parameter int         DEPTH     = 8,
    parameter int         NUM_PORTS = 4,
    parameter logic [4:0] VERSION   = 5'd2,
    parameter int         RST_HOLD  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [5:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic        host_rvalid,
    output logic [31:0] host_rdata,
    output logic        cmd_valid,
    output logic [31:0] cmd_word,
    output logic [15:0] mode_clk_div,
    output logic [5:0]  mode_port,
    output logic        mode_enhanced,
    output logic        mode_diag,
    output logic        mode_pace,
    output logic        mode_wrap,
    output logic        eng_rst,
    input  logic        eng_push,
    input  logic [7:0]  eng_push_data,
    input  logic        eng_pop,
    output logic [7:0]  eng_pop_data,
    output logic        fifo_empty,
    output logic        fifo_full,
    input  logic [5:0]  eng_err,
    input  logic        eng_dat_req,
    input  logic        eng_cmd_comp,
    input  logic        eng_self_busy,
    input  logic        eng_port_busy_set,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        wm_high,
    output logic        wm_low
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [3:0] MAX_PORT = 4'(NUM_PORTS - 1);

    wr_strobe_t        wr_stb;
    logic              rd_fifo;
    logic              soft_clr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] mode_q;
    logic [WORD_W-1:0] wm_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [7:0]        cnt8;
    logic [7:0]        fifo_head;
    logic              host_ovr;
    err_flags_t        errs;
    logic              port_busy;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] estat_word;

    i2cfe_ctrl #(.RST_HOLD(RST_HOLD)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .rd_word    (rd_word),
        .host_ready (host_ready),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .wr_stb     (wr_stb),
        .rd_fifo    (rd_fifo),
        .soft_clr   (soft_clr)
    );

    i2cfe_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_clr),
        .push_host(wr_stb.fifo),
        .din_host (host_wdata[7:0]),
        .push_eng (eng_push),
        .din_eng  (eng_push_data),
        .pop_host (rd_fifo),
        .pop_eng  (eng_pop),
        .head     (fifo_head),
        .count    (fifo_cnt),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .host_ovr (host_ovr)
    );

    i2cfe_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .err_clr  (wr_stb.err_clear),
        .eng_err  (eng_err),
        .ovr_set  (host_ovr),
        .pbusy_set(eng_port_busy_set),
        .pbusy_clr(wr_stb.pbusy && host_wdata[PBUSY_CLR_BIT]),
        .errs     (errs),
        .port_busy(port_busy)
    );

    // configuration and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            wm_q      <= '0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else if (soft_clr) begin
            mode_q    <= '0;
            wm_q      <= '0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            if (wr_stb.mode)  mode_q   <= host_wdata & MODE_KEEP;
            if (wr_stb.wmark) wm_q     <= host_wdata & WMARK_KEEP;
            if (wr_stb.cmd)   cmd_word <= host_wdata;
            cmd_valid <= wr_stb.cmd;
        end
    end

    assign mode_clk_div  = mode_q[31:16];
    assign mode_port     = mode_q[15:10];
    assign mode_enhanced = mode_q[3];
    assign mode_diag     = mode_q[2];
    assign mode_pace     = mode_q[1];
    assign mode_wrap     = mode_q[0];

    assign eng_rst      = soft_clr;
    assign eng_pop_data = fifo_head;
    assign cnt8         = 8'(fifo_cnt);
    assign wm_high      = (cnt8 >= {4'b0, wm_q[15:12]});
    assign wm_low       = (cnt8 <= {4'b0, wm_q[7:4]});

    always_comb begin
        stat_word        = '0;
        stat_word[31]    = errs.inv_cmd;
        stat_word[30]    = errs.parity;
        stat_word[29]    = errs.overrun;
        stat_word[28]    = errs.access;
        stat_word[27]    = errs.lost_arb;
        stat_word[26]    = errs.nack;
        stat_word[25]    = eng_dat_req;
        stat_word[24]    = eng_cmd_comp;
        stat_word[23]    = errs.stop_err;
        stat_word[19:16] = MAX_PORT;
        stat_word[15]    = |errs;
        stat_word[11]    = scl_in;
        stat_word[10]    = sda_in;
        stat_word[9]     = port_busy;
        stat_word[8]     = eng_self_busy;
        stat_word[7:0]   = cnt8;
    end

    always_comb begin
        estat_word        = '0;
        estat_word[31:24] = 8'(DEPTH);
        estat_word[9]     = wm_high;
        estat_word[8]     = wm_low;
        estat_word[4:0]   = VERSION;
    end

    always_comb begin
        unique case (host_addr)
            OFS_FIFO:  rd_word = fifo_empty ? '0 : {24'b0, fifo_head};
            OFS_CMD:   rd_word = cmd_word;
            OFS_MODE:  rd_word = mode_q;
            OFS_WMARK: rd_word = wm_q;
            OFS_STAT:  rd_word = stat_word;
            OFS_ESTAT: rd_word = estat_word;
            default:   rd_word = '0;
        endcase
    end

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |=> (fifo_empty && mode_q == '0 && !port_busy && errs == '0))
        else $error("R8: engine reset did not clear state");
endmodule

// File: tb/tb_i2c_host_regfile.sv
`timescale 1ns/1ps
module tb_i2c_host_regfile;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic [15:0] mode_clk_div;
    logic [5:0]  mode_port;
    logic        mode_enhanced, mode_diag, mode_pace, mode_wrap;
    logic        eng_rst;
    logic        eng_push = 1'b0;
    logic [7:0]  eng_push_data = '0;
    logic        eng_pop = 1'b0;
    logic [7:0]  eng_pop_data;
    logic        fifo_empty, fifo_full;
    logic [5:0]  eng_err = '0;
    logic        eng_dat_req = 1'b0;
    logic        eng_cmd_comp = 1'b0;
    logic        eng_self_busy = 1'b0;
    logic        eng_port_busy_set = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        wm_high, wm_low;

    int nvec = 0;
    int nfail = 0;

    localparam logic [31:0] STAT_IDLE = 32'h0003_0C00;

    always #(HALF) clk = ~clk;

    i2c_host_regfile dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic [31:0] d);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [5:0] a, output logic [31:0] d);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        chk("R12 rvalid/ready", {30'b0, host_rvalid, host_ready}, 32'h2);
        d = host_rdata;
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        host_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic eng_pulse_err(input logic [5:0] e);
        eng_err = e;
        @(negedge clk);
        eng_err = '0;
    endtask

    task automatic eng_push_byte(input logic [7:0] b);
        eng_push = 1'b1; eng_push_data = b;
        @(negedge clk);
        eng_push = 1'b0;
    endtask

    task automatic eng_pop_chk(input string req, input logic [7:0] exp);
        chk(req, {24'b0, eng_pop_data}, {24'b0, exp});
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        read_chk("R1 mode", 6'h08, 32'h0);
        read_chk("R1 wmark", 6'h0C, 32'h0);
        read_chk("R1 cmd", 6'h04, 32'h0);
        read_chk("R1 status", 6'h1C, STAT_IDLE);
        read_chk("R1 estatus", 6'h20, 32'h0800_0302);
    endtask

    task automatic t_mode();
        host_write(6'h08, 32'hFFFF_FFFF);
        read_chk("R2 mode mask", 6'h08, 32'hFFFF_FC0F);
        host_write(6'h08, 32'h0006_0C08);
        chk("R2 fields", {mode_clk_div, 2'b0, mode_port, 4'b0, mode_enhanced, mode_diag, mode_pace, mode_wrap},
            {16'h0006, 2'b0, 6'd3, 4'b0, 4'b1000});
    endtask

    task automatic t_watermark();
        host_write(6'h0C, 32'hFFFF_FFFF);
        read_chk("R3 wmark mask", 6'h0C, 32'h0000_F0F0);
        host_write(6'h0C, 32'h0000_3010);
        read_chk("R3 count0", 6'h20, 32'h0800_0102);
        host_write(6'h00, 32'h1);
        host_write(6'h00, 32'h2);
        read_chk("R3 count2", 6'h20, 32'h0800_0002);
        host_write(6'h00, 32'h3);
        read_chk("R3 count3", 6'h20, 32'h0800_0202);
        chk("R3 ports", {30'b0, wm_high, wm_low}, 32'h2);
        for (int i = 1; i <= 3; i++) eng_pop_chk("R4 drain", 8'(i));
        host_write(6'h0C, 32'h0);
    endtask

    task automatic t_fifo_eng_to_host();
        eng_push_byte(8'h11);
        eng_push_byte(8'h22);
        eng_push_byte(8'h33);
        read_chk("R4 count", 6'h1C, STAT_IDLE | 32'h3);
        read_chk("R4 byte0", 6'h00, 32'h11);
        read_chk("R4 byte1", 6'h00, 32'h22);
        read_chk("R4 byte2", 6'h00, 32'h33);
        read_chk("R4 empty", 6'h1C, STAT_IDLE);
    endtask

    task automatic t_overrun();
        read_chk("R5 empty read", 6'h00, 32'h0);
        read_chk("R5 ovr flag", 6'h1C, STAT_IDLE | 32'h2000_8000);
        host_write(6'h20, 32'h0);
        read_chk("R7 ovr cleared", 6'h1C, STAT_IDLE);
        for (int i = 0; i < 8; i++) host_write(6'h00, 32'hFFFF_FFA0 + 32'(i));
        chk("R4 full", {31'b0, fifo_full}, 32'h1);
        host_write(6'h00, 32'h0000_00EE);
        read_chk("R5 full write", 6'h1C, STAT_IDLE | 32'h2000_8008);
        for (int i = 0; i < 8; i++) eng_pop_chk("R5 contents", 8'hA0 + 8'(i));
        chk("R5 no extra", {31'b0, fifo_empty}, 32'h1);
        host_write(6'h20, 32'h0);
    endtask

    task automatic t_errors();
        eng_pulse_err(6'b11_1111);
        read_chk("R6 sticky bits", 6'h1C, STAT_IDLE | 32'hDC80_8000);
        host_write(6'h20, 32'h0);
        read_chk("R7 cleared", 6'h1C, STAT_IDLE);
        eng_pulse_err(6'b01_0000);
        read_chk("R6 nack only", 6'h1C, STAT_IDLE | 32'h0400_8000);
        host_write(6'h20, 32'h0);
    endtask

    task automatic t_live();
        eng_dat_req = 1'b1; eng_cmd_comp = 1'b1; eng_self_busy = 1'b1; scl_in = 1'b0;
        read_chk("R11 live", 6'h1C, 32'h0303_0500);
        eng_dat_req = 1'b0; eng_cmd_comp = 1'b0; eng_self_busy = 1'b0; scl_in = 1'b1; sda_in = 1'b0;
        read_chk("R11 sda", 6'h1C, 32'h0003_0800);
        sda_in = 1'b1;
    endtask

    task automatic t_port_busy();
        eng_port_busy_set = 1'b1;
        @(negedge clk);
        eng_port_busy_set = 1'b0;
        read_chk("R9 set", 6'h1C, STAT_IDLE | 32'h200);
        host_write(6'h28, 32'h7FFF_FFFF);
        read_chk("R9 no bit31", 6'h1C, STAT_IDLE | 32'h200);
        host_write(6'h28, 32'h8000_0000);
        read_chk("R9 cleared", 6'h1C, STAT_IDLE);
    endtask

    task automatic t_cmd();
        host_write(6'h04, 32'h9234_0005);
        chk("R10 strobe", {31'b0, cmd_valid}, 32'h1);
        chk("R10 word", cmd_word, 32'h9234_0005);
        @(negedge clk);
        chk("R10 one cycle", {31'b0, cmd_valid}, 32'h0);
        read_chk("R10 readback", 6'h04, 32'h9234_0005);
    endtask

    task automatic t_engine_reset();
        int n;
        host_write(6'h08, 32'h1234_5678);
        host_write(6'h0C, 32'h0000_5050);
        host_write(6'h00, 32'h55);
        eng_pulse_err(6'b00_0100);
        eng_port_busy_set = 1'b1;
        @(negedge clk);
        eng_port_busy_set = 1'b0;
        host_write(6'h1C, 32'h0);
        n = 0;
        while (eng_rst && n < 50) begin
            if (host_ready) n = 100;
            n++;
            @(negedge clk);
        end
        chk("R8 hold cycles", 32'(n), 32'd4);
        read_chk("R8 mode", 6'h08, 32'h0);
        read_chk("R8 wmark", 6'h0C, 32'h0);
        read_chk("R8 cmd", 6'h04, 32'h0);
        read_chk("R8 status", 6'h1C, STAT_IDLE);
        chk("R8 mode port", {16'b0, mode_clk_div}, 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        #(HALF * 2.0 * 100000.0);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_mode();
        t_watermark();
        t_fifo_eng_to_host();
        t_overrun();
        t_errors();
        t_live();
        t_port_busy();
        t_cmd();
        t_engine_reset();
        summary();
        $finish;
    end
endmodule